// File: doc/BRIEF.md
# Hardware Counting Semaphore

This block holds a counting semaphore that several requesters share, each known by a small numeric ID. A requester asks for a slot on the wait channel and gives one back on the post channel. If a slot is free, the semaphore grants it at once. If not, the requester's ID joins a first-in first-out queue. A later post wakes the oldest queued requester directly and does not raise the count, so a newcomer can never take the freed slot ahead of it.

When nobody waits, a post raises the count up to a configured ceiling. A post beyond that ceiling is dropped and flagged. Two sticky flags report a post against a full count and a wait against a full queue. The count and the queue occupancy are visible at all times. If the initial count is set to zero, the block acts as an event flag: a wait stays blocked until a post arrives.

Both command channels accept every cycle. A wait and a post may arrive in the same cycle, and the post then takes effect first. Each grant is a single-cycle pulse that carries the ID of the requester it releases. It appears in the cycle after the command that caused it.

Top module: `sema_unit`

## Requirements
- R1: After reset the count equals the INIT_CNT parameter, the queue is empty, no grant is asserted and both error flags are clear.
- R2: A wait that finds the count above zero (after any same-cycle post) decrements the count and, one cycle later, pulses grantValid with grantId equal to the waiting ID.
- R3: A wait that finds the count at zero leaves the count unchanged, raises queueLevel by one and produces no grant.
- R4: A post with an empty queue and a count below MAX_CNT raises the count by one and produces no grant.
- R5: A post with an empty queue and the count at MAX_CNT leaves the count unchanged and sets saturateErr, which stays set until reset; the count never exceeds MAX_CNT.
- R6: A post with a non-empty queue leaves the count at zero, removes the oldest queued ID, and one cycle later pulses grantValid with that ID. Queued IDs are granted in the order they arrived.
- R7: grantValid is high for one cycle per grant and is low in a cycle that follows an idle command cycle.
- R8: When a wait and a post arrive in the same cycle, the post is applied first: with an empty queue and a zero count, the waiter is granted and the count stays zero. With a full queue, the head is granted and the new waiter is queued without an overflow.
- R9: A wait that would be queued while the queue already holds NUM_REQ IDs, with no same-cycle post, is dropped: queueLevel stays at NUM_REQ, no grant is issued, and overflowErr is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| waitValid | input | 1 | Wait (acquire) request this cycle |
| waitId | input | ID_W | ID of the requester issuing the wait |
| waitReady | output | 1 | Wait channel accepts; always high |
| postValid | input | 1 | Post (release) request this cycle |
| postReady | output | 1 | Post channel accepts; always high |
| grantValid | output | 1 | One-cycle grant pulse |
| grantId | output | ID_W | ID of the granted requester |
| count | output | CNT_W | Current semaphore count |
| queueLevel | output | LVL_W | Number of queued waiters |
| overflowErr | output | 1 | Sticky: wait dropped because the queue was full |
| saturateErr | output | 1 | Sticky: post dropped because the count was at its ceiling |

## Verification
The assertions assume that waitId is always below NUM_REQ. They also assume that MAX_CNT and INIT_CNT fit in CNT_W bits, with INIT_CNT no larger than MAX_CNT. Under those assumptions the count can be checked against its ceiling, and any non-empty queue must coincide with a zero count. The bench drives only IDs 0 to 3 with four requesters, a ceiling of 3 and an initial count of 1. It changes inputs only on falling edges, so every command is seen whole by exactly one rising edge. Deliberate overflow is the only case where the stimulus pushes past the queue depth.

// File: rtl/sema_pkg.sv
package sema_pkg;

  // Strobes issued by the control decision to the datapath each cycle
  typedef struct packed {
    logic incCnt;    // raise the count by one
    logic decCnt;    // lower the count by one
    logic push;      // enqueue the waiting ID
    logic pop;       // dequeue the head ID and grant it
    logic grantImm;  // grant the waiting ID directly
    logic setOvf;    // wait dropped on a full queue
    logic setSat;    // post dropped on a full count
  } semaStrb_t;

endpackage

// File: rtl/sema_idfifo.sv
module sema_idfifo #(
  parameter int DEPTH = 4,
  parameter int ID_W  = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         push,
  input  logic                         pop,
  input  logic [ID_W-1:0]              dIn,
  output logic [ID_W-1:0]              head,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         empty,
  output logic                         full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ID_W-1:0]  slots [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [LVL_W-1:0] fill;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      fill  <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (push && wrPtr == PTR_W'(g)) slots[g] <= dIn;
    end
  end

  assign head  = slots[rdPtr];
  assign level = fill;
  assign empty = (fill == '0);
  assign full  = (fill == LVL_W'(DEPTH));

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> fill != '0); // R6
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |-> fill != LVL_W'(DEPTH)); // R9

endmodule

// File: rtl/sema_ctrl.sv
module sema_ctrl
  import sema_pkg::*;
(
  input  logic      postValid,
  input  logic      waitValid,
  input  logic      cntZero,
  input  logic      cntAtMax,
  input  logic      qEmpty,
  input  logic      qFull,
  output semaStrb_t strb
);

  logic cntPos;

  always_comb begin
    strb = '0;
    // post first: wake the head waiter, else count up to the ceiling
    strb.pop    = postValid && !qEmpty;
    strb.incCnt = postValid && qEmpty && !cntAtMax;
    strb.setSat = postValid && qEmpty && cntAtMax;
    // then wait, against the count as the post left it
    cntPos        = !cntZero || strb.incCnt;
    strb.grantImm = waitValid && cntPos;
    strb.decCnt   = strb.grantImm;
    strb.push     = waitValid && !cntPos && (!qFull || strb.pop);
    strb.setOvf   = waitValid && !cntPos && qFull && !strb.pop;
  end

endmodule

// File: rtl/sema_dp.sv
module sema_dp
  import sema_pkg::*;
#(
  parameter int NUM_REQ  = 4,
  parameter int CNT_W    = 4,
  parameter int MAX_CNT  = 8,
  parameter int INIT_CNT = 1,
  localparam int ID_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int LVL_W   = $clog2(NUM_REQ + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  semaStrb_t         strb,
  input  logic [ID_W-1:0]   waitId,
  output logic              cntZero,
  output logic              cntAtMax,
  output logic              qEmpty,
  output logic              qFull,
  output logic [CNT_W-1:0]  count,
  output logic [LVL_W-1:0]  level,
  output logic              grantValid,
  output logic [ID_W-1:0]   grantId,
  output logic              ovfErr,
  output logic              satErr
);

  logic [CNT_W-1:0] cntQ;
  logic [ID_W-1:0]  headId;

  sema_idfifo #(.DEPTH(NUM_REQ), .ID_W(ID_W)) fifo_i (
    .clk   (clk),
    .rstN  (rstN),
    .push  (strb.push),
    .pop   (strb.pop),
    .dIn   (waitId),
    .head  (headId),
    .level (level),
    .empty (qEmpty),
    .full  (qFull)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ       <= CNT_W'(INIT_CNT);
      grantValid <= 1'b0;
      grantId    <= '0;
      ovfErr     <= 1'b0;
      satErr     <= 1'b0;
    end else begin
      case ({strb.incCnt, strb.decCnt})
        2'b10:   cntQ <= cntQ + 1'b1;
        2'b01:   cntQ <= cntQ - 1'b1;
        default: cntQ <= cntQ;
      endcase
      grantValid <= strb.pop || strb.grantImm;
      if (strb.pop)           grantId <= headId;
      else if (strb.grantImm) grantId <= waitId;
      if (strb.setOvf) ovfErr <= 1'b1;
      if (strb.setSat) satErr <= 1'b1;
    end
  end

  assign count    = cntQ;
  assign cntZero  = (cntQ == '0);
  assign cntAtMax = (cntQ == CNT_W'(MAX_CNT));

  AST_CNT_CEIL: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_W'(MAX_CNT)); // R5
  AST_WAIT_DEC: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decCnt && !strb.incCnt) |=> cntQ == $past(cntQ) - 1'b1); // R2
  AST_POST_INC: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incCnt && !strb.decCnt) |=> cntQ == $past(cntQ) + 1'b1); // R4
  AST_QUEUE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (level != '0) |-> cntQ == '0); // R3
  AST_SINGLE_SRC: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.pop && strb.grantImm)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovfErr |=> ovfErr); // R9
  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    satErr |=> satErr); // R5
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(NUM_REQ)); // R9

endmodule

// File: rtl/sema_unit.sv
module sema_unit
  import sema_pkg::*;
#(
  parameter int NUM_REQ  = 4,
  parameter int CNT_W    = 4,
  parameter int MAX_CNT  = 8,
  parameter int INIT_CNT = 1,
  localparam int ID_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int LVL_W   = $clog2(NUM_REQ + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             waitValid,
  input  logic [ID_W-1:0]  waitId,
  output logic             waitReady,
  input  logic             postValid,
  output logic             postReady,
  output logic             grantValid,
  output logic [ID_W-1:0]  grantId,
  output logic [CNT_W-1:0] count,
  output logic [LVL_W-1:0] queueLevel,
  output logic             overflowErr,
  output logic             saturateErr
);

  semaStrb_t strb;
  logic cntZero, cntAtMax, qEmpty, qFull;

  assign waitReady = 1'b1;
  assign postReady = 1'b1;

  sema_ctrl ctrl_i (
    .postValid (postValid),
    .waitValid (waitValid),
    .cntZero   (cntZero),
    .cntAtMax  (cntAtMax),
    .qEmpty    (qEmpty),
    .qFull     (qFull),
    .strb      (strb)
  );

  sema_dp #(
    .NUM_REQ  (NUM_REQ),
    .CNT_W    (CNT_W),
    .MAX_CNT  (MAX_CNT),
    .INIT_CNT (INIT_CNT)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .waitId     (waitId),
    .cntZero    (cntZero),
    .cntAtMax   (cntAtMax),
    .qEmpty     (qEmpty),
    .qFull      (qFull),
    .count      (count),
    .level      (queueLevel),
    .grantValid (grantValid),
    .grantId    (grantId),
    .ovfErr     (overflowErr),
    .satErr     (saturateErr)
  );

endmodule

// File: tb/sema_unit_tb_top.sv
`timescale 1ns/1ps
module sema_unit_tb_top;

  localparam int NREQ = 4;
  localparam int CW   = 4;
  localparam int MAXC = 3;
  localparam int INIT = 1;
  localparam int IW   = 2;
  localparam int LW   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic waitValid = 1'b0;
  logic [IW-1:0] waitId = '0;
  logic postValid = 1'b0;
  logic waitReady, postReady, grantValid, overflowErr, saturateErr;
  logic [IW-1:0] grantId;
  logic [CW-1:0] count;
  logic [LW-1:0] queueLevel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sema_unit #(.NUM_REQ(NREQ), .CNT_W(CW), .MAX_CNT(MAXC), .INIT_CNT(INIT)) dut_i (
    .clk(clk), .rstN(rstN),
    .waitValid(waitValid), .waitId(waitId), .waitReady(waitReady),
    .postValid(postValid), .postReady(postReady),
    .grantValid(grantValid), .grantId(grantId),
    .count(count), .queueLevel(queueLevel),
    .overflowErr(overflowErr), .saturateErr(saturateErr)
  );

  // {post, wait, waitId[1:0], expGrant, expGrantId[1:0], expCount[3:0], expLevel[2:0]}
  localparam int NV = 15;
  localparam logic [13:0] VEC [NV] = '{
    14'b0_1_00_1_00_0000_000, // R2 wait with count 1
    14'b0_1_01_0_00_0000_001, // R3 wait queued
    14'b0_1_10_0_00_0000_010, // R3 wait queued
    14'b1_0_00_1_01_0000_001, // R6 wake oldest
    14'b1_1_11_1_10_0000_001, // R8 post pops, wait queued
    14'b1_0_00_1_11_0000_000, // R6 wake last
    14'b0_0_00_0_00_0000_000, // R7 idle, no grant
    14'b1_0_00_0_00_0001_000, // R4 count up
    14'b1_0_00_0_00_0010_000, // R4
    14'b1_0_00_0_00_0011_000, // R4 at ceiling
    14'b1_0_00_0_00_0011_000, // R5 saturate
    14'b1_1_01_1_01_0010_000, // R8 post saturates then wait takes
    14'b0_1_10_1_10_0001_000, // R2
    14'b0_1_00_1_00_0000_000, // R2
    14'b1_1_11_1_11_0000_000  // R8 zero count, both
  };
  localparam int TAG [NV] = '{2, 3, 3, 6, 8, 6, 7, 4, 4, 4, 5, 8, 2, 2, 8};

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit p, input bit w, input int id);
    postValid = p;
    waitValid = w;
    waitId    = IW'(id);
    @(negedge clk);
    postValid = 1'b0;
    waitValid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "count", count, INIT);
    chk("R1", "level", queueLevel, 0);
    chk("R1", "grant", grantValid, 0);
    chk("R1", "errors", {overflowErr, saturateErr}, 0);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", TAG[v], v);
      step(VEC[v][13], VEC[v][12], VEC[v][11:10]);
      chk(tag, "grantValid", grantValid, VEC[v][9]);
      if (VEC[v][9]) chk(tag, "grantId", grantId, VEC[v][8:7]);
      chk(tag, "count", count, VEC[v][6:3]);
      chk(tag, "level", queueLevel, VEC[v][2:0]);
    end
    chk("R5", "saturateErr", saturateErr, 1);
    chk("R9", "overflowErr before", overflowErr, 0);

    // fill the queue: ids 0..3
    for (int i = 0; i < NREQ; i++) begin
      step(1'b0, 1'b1, i);
      chk("R3", "fill level", queueLevel, i + 1);
      chk("R3", "fill grant", grantValid, 0);
    end
    // R8 on a full queue: head 0 granted, id 2 queued, no overflow
    step(1'b1, 1'b1, 2);
    chk("R8", "full grant", grantValid, 1);
    chk("R8", "full grantId", grantId, 0);
    chk("R8", "full level", queueLevel, NREQ);
    chk("R8", "no overflow", overflowErr, 0);
    // R9 overflow
    step(1'b0, 1'b1, 3);
    chk("R9", "level held", queueLevel, NREQ);
    chk("R9", "no grant", grantValid, 0);
    chk("R9", "overflowErr", overflowErr, 1);
    // R6 drain in arrival order: 1, 2, 3, 2
    begin
      int order [4] = '{1, 2, 3, 2};
      for (int i = 0; i < 4; i++) begin
        step(1'b1, 1'b0, 0);
        chk("R6", "drain grant", grantValid, 1);
        chk("R6", "drain id", grantId, order[i]);
        chk("R6", "drain count", count, 0);
      end
    end
    step(1'b0, 1'b0, 0);
    chk("R7", "pulse ends", grantValid, 0);
    chk("R9", "overflow sticky", overflowErr, 1);
    step(1'b1, 1'b0, 0);
    chk("R4", "post empty", count, 1);

    // reset again
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "count after reset", count, INIT);
    chk("R1", "level after reset", queueLevel, 0);
    chk("R1", "errors after reset", {overflowErr, saturateErr}, 0);
    chk("R1", "grant after reset", grantValid, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule